// File: doc/BRIEF.md
# Conditional Floating-Point Move Decision Unit

This unit decides whether a conditional quad-precision register move is carried out. It looks at an incoming instruction word. If the word is a conditional move, the unit evaluates the condition the word names against one of three sources:

- one of the four 2-bit floating-point comparison results held in the status register;
- the 32-bit or 64-bit integer flag set (negative, zero, overflow, carry);
- the sign and zero state of a 64-bit integer register.

The decision is combinational. When the condition holds, the unit turns the instruction into an unconditional quad move, so that a downstream executor can perform it. When the condition fails, the unit produces the retire-as-no-op update: the current-exception field is cleared and the program counters step forward. Words that are not conditional moves pass through unchanged. The register read, the data move and the register write all belong to neighbouring logic.

The clock and reset inputs drive only the embedded checks. They hold no state.

Top module: `cfm_cond_eval`

## Requirements
- R1: `valid_o` is 1 only under both of these conditions. First, `insn_i[31:30]`=2'b10 and `insn_i[24:19]`=6'b110101. Second, opf=`insn_i[13:5]` matches one of three forms:
  - floating-point flag form: opf[8]=0 and opf[5:0]=6'b000011;
  - integer flag form: opf[8]=1 and opf[6:0]=7'b0000011;
  - register form: opf[8]=0, opf[4:0]=5'b00111 and opf[6:5]≠0.

  In every other case `take_o`=`skip_o`=0 and all four data outputs equal their inputs.
- R2: In the floating-point flag form, `insn_i[12:11]` picks the comparison result from `fsr_i`: 0 reads bits [11:10], 1 reads [33:32], 2 reads [35:34] and 3 reads [37:36]. The values mean 0 equal, 1 less, 2 greater and 3 unordered.
- R3: In the floating-point flag form, test t=`insn_i[16:14]` holds for the stored value f as follows:
  - t=0: never;
  - t=1: f≠0;
  - t=2: f is 1 or 2;
  - t=3: f[0];
  - t=4: f=1;
  - t=5: f[1];
  - t=6: f=2;
  - t=7: f=3.
- R4: In the integer flag form, `insn_i[12]`=0 uses `icc_i[3:0]` and `insn_i[12]`=1 uses `icc_i[7:4]`. Inside each nibble, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R5: In the integer flag form, test t=`insn_i[16:14]` holds as follows:
  - t=0: never;
  - t=1: Z;
  - t=2: Z or (N xor V);
  - t=3: N xor V;
  - t=4: C or Z;
  - t=5: C;
  - t=6: N;
  - t=7: V.
- R6: In the register form, the value v is `rs1_val_i` taken as signed. It is read as zero when `insn_i[18:14]`=0. With r=`insn_i[11:10]`, the test holds for v=0 when r=1, for v≤0 when r=2 and for v<0 when r=3.
- R7: The test result is inverted when `insn_i[17]`=1 in the two flag forms, and when `insn_i[12]`=1 in the register form.
- R8: On a false condition, `skip_o`=1 and `fsr_o` equals `fsr_i` with bits [4:0] cleared. `pc_o` equals `npc_i`, `npc_o` equals `npc_i`+4, and `insn_o` equals `insn_i`.
- R9: On a true condition, `take_o`=1 and `fsr_o`, `pc_o` and `npc_o` equal their inputs. `insn_o` equals {2'b10, `insn_i[29:25]`, 6'b110100, 5'b0, 9'h003, `insn_i[4:0]`}.
- R10: When `valid_o`=1, exactly one of `take_o` and `skip_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| insn_i | input | 32 | Instruction word under evaluation |
| fsr_i | input | FSR_W | Floating-point status register |
| icc_i | input | 8 | Integer flags: [3:0] 32-bit, [7:4] 64-bit |
| rs1_val_i | input | XLEN | Value of the register named in insn_i[18:14] |
| pc_i | input | PC_W | Current program counter |
| npc_i | input | PC_W | Next program counter |
| valid_o | output | 1 | Word is a conditional quad move |
| take_o | output | 1 | Condition true, move proceeds |
| skip_o | output | 1 | Condition false, retire as no-op |
| insn_o | output | 32 | Rewritten or unchanged instruction |
| fsr_o | output | FSR_W | Status register after the decision |
| pc_o | output | PC_W | Program counter after the decision |
| npc_o | output | PC_W | Next program counter after the decision |

## Verification
The bench builds the unit with its defaults: FSR_W=64, XLEN=64 and PC_W=64. These widths put all four comparison-result slots, including the upper ones at bits 32 to 37, inside the driven status word. They also expose the register sign at bit 63, and they let a next-PC increment carry across the 32-bit boundary.

Every slot and every nibble is surrounded by deliberately contradicting neighbour values, so a wrong selection flips the decision. The current-exception bits start non-zero, so that a skipped move visibly clears them.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int INSN_W = 32;
  localparam int CEXC_W = 5;
  localparam int NUM_FCC = 4;

  typedef enum logic [1:0] {
    FAM_NONE = 2'd0,
    FAM_FCC  = 2'd1,
    FAM_ICC  = 2'd2,
    FAM_REG  = 2'd3
  } cfm_fam_e;

  localparam logic [1:0] OP_ARITH   = 2'b10;
  localparam logic [5:0] OP3_FMOVC  = 6'b110101;
  localparam logic [5:0] OP3_FPLAIN = 6'b110100;
  localparam logic [8:0] OPF_MOVQ   = 9'h003;

  // slot positions of the four fp comparison results in the status word
  function automatic int fcc_lsb(input int idx);
    return (idx == 0) ? 10 : 30 + 2 * idx;
  endfunction
endpackage

// File: rtl/cfm_decode.sv
module cfm_decode
  import cfm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] op_i,
  input  logic [5:0] op3_i,
  input  logic [18:5] fld_i,
  output cfm_fam_e   fam_o,
  output logic [1:0] fcc_sel_o,
  output logic       xcc_sel_o,
  output logic [2:0] cc_test_o,
  output logic       cc_inv_o,
  output logic [1:0] rtest_o,
  output logic       rinv_o,
  output logic       rs1_zero_o
);
  logic [8:0] opf;
  logic       fmov2;

  assign opf   = fld_i[13:5];
  assign fmov2 = (op_i == OP_ARITH) && (op3_i == OP3_FMOVC);

  always_comb begin
    fam_o = FAM_NONE;
    if (fmov2) begin
      if (!opf[8] && opf[5:0] == 6'b000011)                 fam_o = FAM_FCC;
      else if (opf[8] && opf[6:0] == 7'b0000011)            fam_o = FAM_ICC;
      else if (!opf[8] && opf[4:0] == 5'b00111 && |opf[6:5]) fam_o = FAM_REG;
    end
  end

  assign fcc_sel_o  = fld_i[12:11];
  assign xcc_sel_o  = fld_i[12];
  assign cc_test_o  = fld_i[16:14];
  assign cc_inv_o   = fld_i[17];
  assign rtest_o    = fld_i[11:10];
  assign rinv_o     = fld_i[12];
  assign rs1_zero_o = (fld_i[18:14] == 5'd0);

  AST_NOT_FMOV_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fmov2 |-> fam_o == FAM_NONE) else $error("decode family without opcode"); // R1
endmodule

// File: rtl/cfm_fcc_eval.sv
module cfm_fcc_eval
  import cfm_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_FCC-1:0][1:0] slots_i,
  input  logic [1:0]              sel_i,
  input  logic [2:0]              test_i,
  output logic                    hit_o
);
  logic [1:0] f;

  assign f = slots_i[sel_i];

  always_comb begin
    unique case (test_i)
      3'd0:    hit_o = 1'b0;
      3'd1:    hit_o = (f != 2'd0);
      3'd2:    hit_o = (f == 2'd1) || (f == 2'd2);
      3'd3:    hit_o = f[0];
      3'd4:    hit_o = (f == 2'd1);
      3'd5:    hit_o = f[1];
      3'd6:    hit_o = (f == 2'd2);
      default: hit_o = (f == 2'd3);
    endcase
  end

  AST_FCC_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i == 3'd0 |-> !hit_o) else $error("fcc never test hit"); // R3
  AST_FCC_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i == 3'd7 |-> hit_o == (slots_i[sel_i] == 2'd3)) else $error("fcc unordered"); // R3
endmodule

// File: rtl/cfm_icc_eval.sv
module cfm_icc_eval (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] icc_i,
  input  logic       xcc_i,
  input  logic [2:0] test_i,
  output logic       hit_o
);
  logic [3:0] nib;
  logic n, z, v, c, lt;

  assign nib = xcc_i ? icc_i[7:4] : icc_i[3:0];
  assign {n, z, v, c} = nib;
  assign lt = n ^ v;

  always_comb begin
    unique case (test_i)
      3'd0:    hit_o = 1'b0;
      3'd1:    hit_o = z;
      3'd2:    hit_o = z | lt;
      3'd3:    hit_o = lt;
      3'd4:    hit_o = c | z;
      3'd5:    hit_o = c;
      3'd6:    hit_o = n;
      default: hit_o = v;
    endcase
  end

  AST_ICC_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i == 3'd6 |-> hit_o == (xcc_i ? icc_i[7] : icc_i[3])) else $error("icc neg"); // R5
  AST_ICC_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i == 3'd0 |-> !hit_o) else $error("icc never"); // R5
endmodule

// File: rtl/cfm_reg_eval.sv
module cfm_reg_eval #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] val_i,
  input  logic            spec_zero_i,
  input  logic [1:0]      test_i,
  output logic            hit_o
);
  logic is_zero, is_neg;

  assign is_zero = spec_zero_i || (val_i == '0);
  assign is_neg  = !spec_zero_i && val_i[XLEN-1];

  always_comb begin
    unique case (test_i)
      2'd1:    hit_o = is_zero;
      2'd2:    hit_o = is_zero | is_neg;
      2'd3:    hit_o = is_neg;
      default: hit_o = 1'b0;
    endcase
  end

  AST_REG_SPEC0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_zero_i && test_i == 2'd3) |-> !hit_o) else $error("reg0 negative"); // R6
endmodule

// File: rtl/cfm_cond_eval.sv
module cfm_cond_eval
  import cfm_pkg::*;
#(
  parameter int FSR_W = 64,
  parameter int XLEN  = 64,
  parameter int PC_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       insn_i,
  input  logic [FSR_W-1:0]  fsr_i,
  input  logic [7:0]        icc_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   npc_i,
  output logic              valid_o,
  output logic              take_o,
  output logic              skip_o,
  output logic [31:0]       insn_o,
  output logic [FSR_W-1:0]  fsr_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  cfm_fam_e   fam;
  logic [1:0] fcc_sel, rtest;
  logic       xcc_sel, cc_inv, rinv, rs1_zero;
  logic [2:0] cc_test;
  logic       fcc_hit, icc_hit, reg_hit, cond;
  logic [NUM_FCC-1:0][1:0] slots;

  for (genvar g = 0; g < NUM_FCC; g++) begin : g_slot
    assign slots[g] = fsr_i[fcc_lsb(g) +: 2];
  end

  cfm_decode u_dec (
    .clk_i, .rst_ni,
    .op_i(insn_i[31:30]), .op3_i(insn_i[24:19]), .fld_i(insn_i[18:5]),
    .fam_o(fam), .fcc_sel_o(fcc_sel), .xcc_sel_o(xcc_sel),
    .cc_test_o(cc_test), .cc_inv_o(cc_inv), .rtest_o(rtest),
    .rinv_o(rinv), .rs1_zero_o(rs1_zero)
  );

  cfm_fcc_eval u_fcc (
    .clk_i, .rst_ni, .slots_i(slots), .sel_i(fcc_sel),
    .test_i(cc_test), .hit_o(fcc_hit)
  );

  cfm_icc_eval u_icc (
    .clk_i, .rst_ni, .icc_i, .xcc_i(xcc_sel),
    .test_i(cc_test), .hit_o(icc_hit)
  );

  cfm_reg_eval #(.XLEN(XLEN)) u_reg (
    .clk_i, .rst_ni, .val_i(rs1_val_i), .spec_zero_i(rs1_zero),
    .test_i(rtest), .hit_o(reg_hit)
  );

  always_comb begin
    unique case (fam)
      FAM_FCC: cond = fcc_hit ^ cc_inv;
      FAM_ICC: cond = icc_hit ^ cc_inv;
      FAM_REG: cond = reg_hit ^ rinv;
      default: cond = 1'b0;
    endcase
  end

  assign valid_o = (fam != FAM_NONE);
  assign take_o  = valid_o && cond;
  assign skip_o  = valid_o && !cond;

  always_comb begin
    insn_o = insn_i;
    fsr_o  = fsr_i;
    pc_o   = pc_i;
    npc_o  = npc_i;
    if (take_o) begin
      insn_o = {OP_ARITH, insn_i[29:25], OP3_FPLAIN, 5'd0, OPF_MOVQ, insn_i[4:0]};
    end else if (skip_o) begin
      fsr_o[CEXC_W-1:0] = '0;
      pc_o  = npc_i;
      npc_o = npc_i + PC_STEP;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones({take_o, skip_o}) == 1) else $error("outcome count"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!take_o && !skip_o && insn_o == insn_i)) else $error("idle drove"); // R1
  AST_SKIP_CEXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> fsr_o[CEXC_W-1:0] == '0) else $error("cexc kept"); // R8
  AST_TAKE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (fsr_o == fsr_i && pc_o == pc_i && npc_o == npc_i)) else $error("take moved"); // R9
endmodule

// File: tb/cfm_cond_eval_tb.sv
module cfm_cond_eval_tb;
  localparam int FSR_W = 64;
  localparam int XLEN  = 64;
  localparam int PC_W  = 64;
  localparam int NVEC  = 37;

  // {fam[15:14], sel[13:12], cond[11:8], data[7:4], 3'b0, exp[0]}
  // fam 0 fp flags, 1 integer flags, 2 register; reg data 0 zero, 1 positive, 2 negative
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0100, 16'h0131, 16'h1230, 16'h2221, 16'h3311, 16'h3320, 16'h1411,
    16'h0510, 16'h2621, 16'h0731, 16'h1700, 16'h0030, 16'h0801, 16'h2901,
    16'h4141, 16'h5100, 16'h4281, 16'h42A0, 16'h5321, 16'h4411, 16'h44A0,
    16'h5511, 16'h4670, 16'h4721, 16'h40F0, 16'h4BA1,
    16'h8101, 16'h8110, 16'h8201, 16'h8221, 16'h8210, 16'h8300, 16'h8321,
    16'h8511, 16'h8600, 16'h8720, 16'h8701
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] insn;
  logic [FSR_W-1:0] fsr;
  logic [7:0] icc;
  logic [XLEN-1:0] rval;
  logic [PC_W-1:0] pc, npc;
  logic valid, take, skip;
  logic [31:0] insn_q;
  logic [FSR_W-1:0] fsr_q;
  logic [PC_W-1:0] pc_q, npc_q;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cfm_cond_eval #(.FSR_W(FSR_W), .XLEN(XLEN), .PC_W(PC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .insn_i(insn), .fsr_i(fsr), .icc_i(icc),
    .rs1_val_i(rval), .pc_i(pc), .npc_i(npc), .valid_o(valid), .take_o(take),
    .skip_o(skip), .insn_o(insn_q), .fsr_o(fsr_q), .pc_o(pc_q), .npc_o(npc_q)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [31:0] mk_insn(input logic [1:0] fam, input logic [1:0] sel,
                                          input logic [3:0] cnd);
    logic [31:0] w;
    w = {2'b10, 5'h0B, 6'b110101, 1'b0, cnd, 9'd0, 5'h15};
    case (fam)
      2'd0: w[13:5] = {1'b0, sel, 6'b000011};
      2'd1: w[13:5] = {1'b1, sel[0], 7'b0000011};
      default: begin
        w[18:14] = 5'd5;
        w[13:5]  = {1'b0, cnd[2:0], 5'b00111};
      end
    endcase
    return w;
  endfunction

  task automatic check_outcome(input bit exp_take, input string req);
    logic [31:0] exp_insn;
    logic [FSR_W-1:0] exp_fsr;
    exp_insn = {2'b10, insn[29:25], 6'b110100, 5'd0, 9'h003, insn[4:0]};
    exp_fsr = {fsr[FSR_W-1:5], 5'd0};
    chk(valid == 1'b1, {req, " valid"}, 64'(valid), 64'd1);
    chk(take == exp_take, {req, " R10 take"}, 64'(take), 64'(exp_take));
    chk(skip == !exp_take, {req, " R10 skip"}, 64'(skip), 64'(!exp_take));
    if (exp_take) begin
      chk(insn_q == exp_insn, "R9 insn", 64'(insn_q), 64'(exp_insn));
      chk(fsr_q == fsr && pc_q == pc && npc_q == npc, "R9 state kept", fsr_q, fsr);
    end else begin
      chk(fsr_q == exp_fsr, "R8 fsr", fsr_q, exp_fsr);
      chk(pc_q == npc, "R8 pc", pc_q, npc);
      chk(npc_q == npc + 64'd4, "R8 npc", npc_q, npc + 64'd4);
      chk(insn_q == insn, "R8 insn", 64'(insn_q), 64'(insn));
    end
  endtask

  task automatic check_idle(input string req);
    chk(!valid && !take && !skip, {req, " flags"}, 64'({valid, take, skip}), 64'd0);
    chk(insn_q == insn && fsr_q == fsr && pc_q == pc && npc_q == npc,
        {req, " passthrough"}, 64'(insn_q), 64'(insn));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    insn = '0;
    fsr  = 64'hDEAD_BE00_0000_001F;
    icc  = '0;
    rval = '0;
    pc   = 64'h1000;
    npc  = 64'h1004;
    repeat (3) @(negedge clk);
    #1;
    check_idle("R1 reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] fam, sel;
      logic [3:0] cnd, dat;
      fam = VEC[i][15:14];
      sel = VEC[i][13:12];
      cnd = VEC[i][11:8];
      dat = VEC[i][7:4];
      insn = mk_insn(fam, sel, cnd);
      fsr  = 64'hDEAD_BE00_0000_001F;
      icc  = '0;
      rval = 64'h0123;
      if (fam == 2'd0) begin
        // other slots hold the complement so a wrong pick flips the result (R2)
        for (int s = 0; s < 4; s++) begin
          int lsb;
          lsb = (s == 0) ? 10 : 30 + 2 * s;
          fsr[lsb +: 2] = (s == int'(sel)) ? dat[1:0] : ~dat[1:0];
        end
      end else if (fam == 2'd1) begin
        icc = sel[0] ? {dat, ~dat} : {~dat, dat};  // R4
      end else begin
        rval = (dat == 4'd0) ? 64'd0 : (dat == 4'd1) ? 64'd5 : 64'hFFFF_FFFF_FFFF_FFFD;
      end
      pc  = 64'h2000 + 64'(i * 8);
      npc = pc + 64'd4;
      apply();
      check_outcome(VEC[i][0], (fam == 2'd0) ? "R2 R3 R7" : (fam == 2'd1) ? "R4 R5 R7" : "R6 R7");
    end

    // R6 register 0 reads as zero whatever the supplied value
    insn = mk_insn(2'd2, 2'd0, 4'd3);
    insn[18:14] = 5'd0;
    rval = 64'h8000_0000_0000_0000;
    apply();
    check_outcome(1'b0, "R6 reg0 lt");
    insn = mk_insn(2'd2, 2'd0, 4'd1);
    insn[18:14] = 5'd0;
    rval = 64'h55;
    apply();
    check_outcome(1'b1, "R6 reg0 zero");

    // R8 next-pc increment carries past bit 31
    insn = mk_insn(2'd1, 2'd0, 4'd0);
    npc  = 64'h0000_0000_FFFF_FFFC;
    pc   = 64'h0000_0000_FFFF_FFF8;
    apply();
    check_outcome(1'b0, "R8 carry");

    // R1 non-conditional words
    insn = {2'b10, 5'h0B, 6'b110100, 5'd0, 9'h003, 5'h15};
    apply();
    check_idle("R1 plain fp op");
    insn = {2'b10, 5'h0B, 6'b110101, 5'd0, 9'h007, 5'h15};
    apply();
    check_idle("R1 rcond zero");
    insn = {2'b10, 5'h0B, 6'b110101, 5'd0, 9'h053, 5'h15};
    apply();
    check_idle("R1 compare");
    insn = {2'b11, 5'h0B, 6'b110101, 5'd0, 9'h003, 5'h15};
    apply();
    check_idle("R1 wrong op");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule